// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

The block couples two parallel ports, A and B, through a set of identical lanes called halves. Each half has its own active-low output enable, its own direction control, two source selects and two store strobes. Each half holds one word per direction: the forward register takes A-port data and the reverse register takes B-port data. An enabled half drives one port at a time. That port shows either the live value arriving on the other port or the word held in the register for that direction. The halves can run as separate narrow transceivers, or they can be driven with common controls and act as one wide transceiver.

Each port is split into an input vector, an output vector and a per-half enable flag, so the block contains no tri-state logic. The store strobes are level inputs sampled on `clk_i`. A store takes place on the clock edge where a strobe is first seen high. It happens whatever the output enable, direction or select is doing. The live path runs from the input pins to the output pins through logic only. The selects are registered. The output multiplexer is built as a sum of products that includes a consensus term, so flipping a select cannot disturb an output whose two candidate values are equal.

Top module: `reg_bus_xcvr`

## Requirements
- R1: Each half reacts only to its own control bits. Half h owns data bits [h*HALF_W +: HALF_W] of every data vector and bit h of every control and enable vector.
- R2: On the first clock edge at which `store_ab_i[h]` is high after having been low, the forward register of half h loads that half's `a_i` slice. At all other edges the register holds its value.
- R3: On the first clock edge at which `store_ba_i[h]` is high after having been low, the reverse register of half h loads that half's `b_i` slice. At all other edges the register holds its value.
- R4: A store takes place whatever the values of `oe_ni`, `dir_i` and the selects. This includes a half that is isolated.
- R5: While `oe_ni[h]` is 1, `a_oe_o[h]` and `b_oe_o[h]` are 0 and that half's `a_o` and `b_o` slices are 0.
- R6: With `oe_ni[h]`=0 and `dir_i[h]`=0, `a_oe_o[h]`=1 and `b_oe_o[h]`=0. The `a_o` slice equals the live `b_i` slice when the registered `sel_ba_i[h]` is 0, and the reverse register when it is 1. The `b_o` slice is 0.
- R7: With `oe_ni[h]`=0 and `dir_i[h]`=1, `b_oe_o[h]`=1 and `a_oe_o[h]`=0. The `b_o` slice equals the live `a_i` slice when the registered `sel_ab_i[h]` is 0, and the forward register when it is 1. The `a_o` slice is 0.
- R8: `a_oe_o[h]` and `b_oe_o[h]` are never 1 at the same time.
- R9: A select change takes effect at the output after the next clock edge. A change on a live data input appears at the driven output in the same cycle, with no clock edge in between.
- R10: When the live value equals the stored value, a driven output keeps that value while its select flips.
- R11: `rst_ni`=0 clears both registers of every half to 0 and sets both registered selects to live.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for sampling store strobes and selects |
| rst_ni | input | 1 | Asynchronous reset, active low |
| oe_ni | input | NUM_HALVES | Output enable per half, active low |
| dir_i | input | NUM_HALVES | Direction per half: 1 drives B, 0 drives A |
| sel_ab_i | input | NUM_HALVES | Source for B output: 0 live A, 1 forward register |
| sel_ba_i | input | NUM_HALVES | Source for A output: 0 live B, 1 reverse register |
| store_ab_i | input | NUM_HALVES | Forward store strobe per half |
| store_ba_i | input | NUM_HALVES | Reverse store strobe per half |
| a_i | input | NUM_HALVES*HALF_W | A-port input data |
| b_i | input | NUM_HALVES*HALF_W | B-port input data |
| a_o | output | NUM_HALVES*HALF_W | A-port output data, 0 where not driven |
| a_oe_o | output | NUM_HALVES | A-port drive enable per half |
| b_o | output | NUM_HALVES*HALF_W | B-port output data, 0 where not driven |
| b_oe_o | output | NUM_HALVES | B-port drive enable per half |

## Verification
The bench builds the block with NUM_HALVES=2 and HALF_W=4. With this size, every data word on both ports can be swept through the live path. Every pairing of the two halves' sixteen control combinations can also be run against a reference model, while the store strobes toggle in a pattern that places stores in every mode. The narrow words also keep the equal-value select toggling and the isolated-store-then-recall sequence short. Because there are two halves, each half can be checked against a different mode in the other half.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_e;

  typedef enum logic [1:0] {
    MODE_ISO   = 2'd0,
    MODE_DRV_A = 2'd1,
    MODE_DRV_B = 2'd2
  } drv_mode_e;

  function automatic drv_mode_e decode_mode(input logic oe_n, input logic dir);
    if (oe_n)     return MODE_ISO;
    else if (dir) return MODE_DRV_B;
    else          return MODE_DRV_A;
  endfunction

endpackage

// File: rtl/xcvr_rise_det.sv
module xcvr_rise_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/xcvr_store_reg.sv
module xcvr_store_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/xcvr_hf_mux.sv
module xcvr_hf_mux
  import xcvr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sel_i,
  input  logic [W-1:0] live_i,
  input  logic [W-1:0] stored_i,
  output logic [W-1:0] y_o
);
  src_e         src_q;
  logic [W-1:0] pick_st;
  logic [W-1:0] pick_lv;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) src_q <= SRC_LIVE;
    else         src_q <= src_e'(sel_i);
  end

  assign pick_st = {W{src_q == SRC_STORED}};
  assign pick_lv = ~pick_st;

  // consensus term keeps equal bits steady across a select flip
  assign y_o = (live_i & pick_lv) | (stored_i & pick_st) | (live_i & stored_i);
endmodule

// File: rtl/xcvr_half.sv
module xcvr_half
  import xcvr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         oe_ni,
  input  logic         dir_i,
  input  logic         sel_ab_i,
  input  logic         sel_ba_i,
  input  logic         store_ab_i,
  input  logic         store_ba_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] a_o,
  output logic         a_oe_o,
  output logic [W-1:0] b_o,
  output logic         b_oe_o
);
  logic         ld_ab, ld_ba;
  logic [W-1:0] fwd_q, rev_q;
  logic [W-1:0] to_b, to_a;
  drv_mode_e    mode;

  xcvr_rise_det u_det_ab (.clk_i, .rst_ni, .lvl_i(store_ab_i), .rise_o(ld_ab));
  xcvr_rise_det u_det_ba (.clk_i, .rst_ni, .lvl_i(store_ba_i), .rise_o(ld_ba));

  xcvr_store_reg #(.W(W)) u_fwd (
    .clk_i, .rst_ni, .load_i(ld_ab), .d_i(a_i), .q_o(fwd_q)
  );
  xcvr_store_reg #(.W(W)) u_rev (
    .clk_i, .rst_ni, .load_i(ld_ba), .d_i(b_i), .q_o(rev_q)
  );

  xcvr_hf_mux #(.W(W)) u_mux_b (
    .clk_i, .rst_ni, .sel_i(sel_ab_i), .live_i(a_i), .stored_i(fwd_q), .y_o(to_b)
  );
  xcvr_hf_mux #(.W(W)) u_mux_a (
    .clk_i, .rst_ni, .sel_i(sel_ba_i), .live_i(b_i), .stored_i(rev_q), .y_o(to_a)
  );

  assign mode   = decode_mode(oe_ni, dir_i);
  assign a_oe_o = (mode == MODE_DRV_A);
  assign b_oe_o = (mode == MODE_DRV_B);
  assign a_o    = a_oe_o ? to_a : '0;
  assign b_o    = b_oe_o ? to_b : '0;
endmodule

// File: rtl/reg_bus_xcvr.sv
module reg_bus_xcvr #(
  parameter int unsigned NUM_HALVES = 2,
  parameter int unsigned HALF_W     = 8,
  localparam int unsigned BUS_W     = NUM_HALVES * HALF_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_HALVES-1:0] oe_ni,
  input  logic [NUM_HALVES-1:0] dir_i,
  input  logic [NUM_HALVES-1:0] sel_ab_i,
  input  logic [NUM_HALVES-1:0] sel_ba_i,
  input  logic [NUM_HALVES-1:0] store_ab_i,
  input  logic [NUM_HALVES-1:0] store_ba_i,
  input  logic [BUS_W-1:0]      a_i,
  input  logic [BUS_W-1:0]      b_i,
  output logic [BUS_W-1:0]      a_o,
  output logic [NUM_HALVES-1:0] a_oe_o,
  output logic [BUS_W-1:0]      b_o,
  output logic [NUM_HALVES-1:0] b_oe_o
);
  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    xcvr_half #(.W(HALF_W)) u_half (
      .clk_i,
      .rst_ni,
      .oe_ni     (oe_ni[h]),
      .dir_i     (dir_i[h]),
      .sel_ab_i  (sel_ab_i[h]),
      .sel_ba_i  (sel_ba_i[h]),
      .store_ab_i(store_ab_i[h]),
      .store_ba_i(store_ba_i[h]),
      .a_i       (a_i[h*HALF_W +: HALF_W]),
      .b_i       (b_i[h*HALF_W +: HALF_W]),
      .a_o       (a_o[h*HALF_W +: HALF_W]),
      .a_oe_o    (a_oe_o[h]),
      .b_o       (b_o[h*HALF_W +: HALF_W]),
      .b_oe_o    (b_oe_o[h])
    );
  end
endmodule

// File: rtl/reg_bus_xcvr_chk.sv
module reg_bus_xcvr_chk #(
  parameter int unsigned NUM_HALVES = 2,
  parameter int unsigned HALF_W     = 8,
  localparam int unsigned BUS_W     = NUM_HALVES * HALF_W
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [NUM_HALVES-1:0] oe_ni,
  input logic [NUM_HALVES-1:0] dir_i,
  input logic [NUM_HALVES-1:0] sel_ab_i,
  input logic [NUM_HALVES-1:0] sel_ba_i,
  input logic [BUS_W-1:0]      a_i,
  input logic [BUS_W-1:0]      b_i,
  input logic [BUS_W-1:0]      a_o,
  input logic [NUM_HALVES-1:0] a_oe_o,
  input logic [BUS_W-1:0]      b_o,
  input logic [NUM_HALVES-1:0] b_oe_o
);
  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_chk
    AST_ONE_DRIVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(a_oe_o[h] && b_oe_o[h])); // R8

    AST_ISOLATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      oe_ni[h] |-> (!a_oe_o[h] && !b_oe_o[h] && a_o[h*HALF_W +: HALF_W] == '0
                    && b_o[h*HALF_W +: HALF_W] == '0)); // R5

    AST_LIVE_TO_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!oe_ni[h] && dir_i[h] && !$past(sel_ab_i[h]))
        |-> (b_oe_o[h] && b_o[h*HALF_W +: HALF_W] == a_i[h*HALF_W +: HALF_W])); // R7

    AST_LIVE_TO_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!oe_ni[h] && !dir_i[h] && !$past(sel_ba_i[h]))
        |-> (a_oe_o[h] && a_o[h*HALF_W +: HALF_W] == b_i[h*HALF_W +: HALF_W])); // R6

    AST_B_QUIET_IN_A_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!oe_ni[h] && !dir_i[h]) |-> (b_o[h*HALF_W +: HALF_W] == '0)); // R6
  end
endmodule

bind reg_bus_xcvr reg_bus_xcvr_chk #(.NUM_HALVES(NUM_HALVES), .HALF_W(HALF_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .oe_ni   (oe_ni),
  .dir_i   (dir_i),
  .sel_ab_i(sel_ab_i),
  .sel_ba_i(sel_ba_i),
  .a_i     (a_i),
  .b_i     (b_i),
  .a_o     (a_o),
  .a_oe_o  (a_oe_o),
  .b_o     (b_o),
  .b_oe_o  (b_oe_o)
);

// File: tb/tb_reg_bus_xcvr.sv
module tb_reg_bus_xcvr;
  localparam int NH = 2;
  localparam int HW = 4;
  localparam int W  = NH * HW;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NH-1:0] oe_ni = '1, dir_i = '0, sel_ab_i = '0, sel_ba_i = '0;
  logic [NH-1:0] store_ab_i = '0, store_ba_i = '0;
  logic [W-1:0]  a_i = '0, b_i = '0;
  logic [W-1:0]  a_o, b_o;
  logic [NH-1:0] a_oe_o, b_oe_o;

  int checks = 0;
  int errors = 0;

  // reference state
  logic [HW-1:0] m_fwd [NH];
  logic [HW-1:0] m_rev [NH];
  logic [NH-1:0] m_sab = '0, m_sba = '0, m_pab = '0, m_pba = '0;

  reg_bus_xcvr #(.NUM_HALVES(NH), .HALF_W(HW)) dut (
    .clk_i(clk), .rst_ni, .oe_ni, .dir_i, .sel_ab_i, .sel_ba_i,
    .store_ab_i, .store_ba_i, .a_i, .b_i, .a_o, .a_oe_o, .b_o, .b_oe_o
  );

  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // advance one edge, updating the reference model at that edge
  task automatic tick();
    for (int h = 0; h < NH; h++) begin
      if (store_ab_i[h] && !m_pab[h]) m_fwd[h] = a_i[h*HW +: HW];
      if (store_ba_i[h] && !m_pba[h]) m_rev[h] = b_i[h*HW +: HW];
    end
    m_pab = store_ab_i;
    m_pba = store_ba_i;
    m_sab = sel_ab_i;
    m_sba = sel_ba_i;
    @(posedge clk);
    #1;
  endtask

  task automatic check_all(input string req);
    for (int h = 0; h < NH; h++) begin
      logic          ea, eb;
      logic [HW-1:0] va, vb;
      ea = !oe_ni[h] && !dir_i[h];
      eb = !oe_ni[h] && dir_i[h];
      va = ea ? (m_sba[h] ? m_rev[h] : b_i[h*HW +: HW]) : '0;
      vb = eb ? (m_sab[h] ? m_fwd[h] : a_i[h*HW +: HW]) : '0;
      chk({req, " a_oe"}, 32'(a_oe_o[h]), 32'(ea));
      chk({req, " b_oe"}, 32'(b_oe_o[h]), 32'(eb));
      chk({req, " a_o"},  32'(a_o[h*HW +: HW]), 32'(va));
      chk({req, " b_o"},  32'(b_o[h*HW +: HW]), 32'(vb));
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int h = 0; h < NH; h++) begin m_fwd[h] = '0; m_rev[h] = '0; end
    repeat (3) @(posedge clk);
    #1;
    // R5 R11: reset, isolated, then recall of cleared registers
    check_all("R5 reset iso");
    rst_ni = 1'b1;
    oe_ni = '0; dir_i = 2'b01; sel_ab_i = '1; sel_ba_i = '1;
    a_i = 8'hA5; b_i = 8'h5A;
    tick();
    check_all("R11 recall after reset");

    // R1 R2 R3 R4 R6 R7: both halves through every control pairing
    for (int m = 0; m < 256; m++) begin
      oe_ni    = {m[4], m[0]};
      dir_i    = {m[5], m[1]};
      sel_ab_i = {m[6], m[2]};
      sel_ba_i = {m[7], m[3]};
      a_i = 8'(m * 37 + 11);
      b_i = 8'(m * 91 + 3);
      store_ab_i = {m[1] ^ m[3], m[0]};
      store_ba_i = {m[2], m[0] ^ m[4]};
      tick();
      check_all("R1 R2 R3 R4 R6 R7 sweep");
    end
    store_ab_i = '0; store_ba_i = '0;
    tick();

    // R7 R9: live A to B, every A word, no edge between drive and sample
    oe_ni = '0; dir_i = '1; sel_ab_i = '0; sel_ba_i = '0;
    tick();
    for (int v = 0; v < 256; v++) begin
      a_i = 8'(v); b_i = 8'(255 - v);
      #0.5;
      chk("R7 R9 live to B", 32'(b_o), 32'(v));
    end
    // R6: live B to A, every B word
    dir_i = '0;
    for (int v = 0; v < 256; v++) begin
      b_i = 8'(v); a_i = 8'(v ^ 8'h3C);
      #0.5;
      chk("R6 live to A", 32'(a_o), 32'(v));
    end
    tick();

    // R4 R5: store while isolated, then recall
    oe_ni = '1;
    a_i = 8'h9C; b_i = 8'h36;
    store_ab_i = '1; store_ba_i = '1;
    tick();
    check_all("R5 isolated during store");
    store_ab_i = '0; store_ba_i = '0;
    a_i = 8'h00; b_i = 8'hFF;
    tick();
    oe_ni = '0; dir_i = '1; sel_ab_i = '1;
    tick();
    chk("R4 recall fwd stored while isolated", 32'(b_o), 32'h9C);
    dir_i = '0; sel_ba_i = '1;
    tick();
    chk("R4 recall rev stored while isolated", 32'(a_o), 32'h36);

    // R2: held strobe stores only once
    dir_i = '1; sel_ab_i = '1;
    a_i = 8'h12; store_ab_i = '1;
    tick();
    a_i = 8'h34;
    tick();
    chk("R2 single store per rising strobe", 32'(b_o), 32'h12);
    store_ab_i = '0;
    tick();

    // R9: select takes effect only after the next edge
    sel_ab_i = '0;
    #0.5;
    chk("R9 select before edge", 32'(b_o), 32'h12);
    tick();
    chk("R9 select after edge", 32'(b_o), 32'h34);

    // R10: live equals stored, output steady while the select toggles
    a_i = 8'h12;
    tick();
    for (int k = 0; k < 20; k++) begin
      sel_ab_i = ~sel_ab_i;
      tick();
      chk("R10 steady at edge", 32'(b_o), 32'h12);
      #0.5;
      chk("R10 steady mid cycle", 32'(b_o), 32'h12);
    end

    // R11: asynchronous reset clears registers
    rst_ni = 1'b0;
    #1;
    rst_ni = 1'b1;
    m_sab = '0; m_sba = '0; m_pab = store_ab_i; m_pba = store_ba_i;
    for (int h = 0; h < NH; h++) begin m_fwd[h] = '0; m_rev[h] = '0; end
    sel_ab_i = '1;
    a_i = 8'h77;
    tick();
    check_all("R11 cleared after reset");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule